// File: doc/BRIEF.md
# Two-Wire Transaction Offload Sequencer

This block runs one complete two-wire bus transfer, a write or a read of 1 to 8 bytes, with no software work per byte. Software first loads the outgoing bytes into two 32-bit transmit words. It then writes a control word that holds the direction, the target address, the address width, the byte count and an enable bit. A rising edge on the enable bit starts the sequencer. The sequencer issues start, address, data and stop commands to a byte-level bus engine through a simple handshake port. It keeps received bytes in two 32-bit receive words. When the transfer ends it records success or failure and sets a cause bit, and the cause bit can raise an interrupt.

Software ends each transfer by writing zero to the control word and to the cause register. Bit-level bus timing belongs to the byte engine and is not part of this block. The byte engine accepts one command at a time. The sequencer holds `cmd_valid`, `cmd_op`, `cmd_data` and `cmd_nack` steady until the engine returns a one-cycle `cmd_done` pulse. With that pulse the engine returns the slave's acknowledge on `cmd_ack_in`, and for a read the received byte on `cmd_rdata`. Command codes are 0 = start, 1 = write byte, 2 = read byte, 3 = stop.

Top module: `tw_offload_top`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `cmd_valid` is low.
- R2: Registers are selected by word index: 0 control, 1 transmit low, 2 transmit high, 3 receive low, 4 receive high, 5 status, 6 cause, 7 mask, 8 timing. Control, both transmit words, mask and timing read back what was written. Writes to status and to the receive words have no effect.
- R3: A transfer starts only when control bit 19 (enable) goes from 0 to 1 while exactly one of bit 0 (write) and bit 1 (read) is set. The commands go in this order: start, address byte(s), data bytes, stop. Writing control again with enable already set does not start a new transfer.
- R4: With control bit 12 clear, the single address byte is control[8:2] shifted left by one, with bit 0 = 1 for a read and 0 for a write.
- R5: With control bit 12 set, the address is control[11:2]. The first address byte is 11110 followed by address bits 9..8 and the direction bit. The second address byte is address bits 7..0.
- R6: A write sends control[15:13]+1 bytes. Byte k comes from bits [8k+7:8k] of the transmit low word for k<4, and from bits [8(k-4)+7:8(k-4)] of the transmit high word otherwise.
- R7: A read fetches control[18:16]+1 bytes. `cmd_nack` is 0 on every read command except the last, where it is 1. Received byte k is stored in the receive words using the same layout as R6.
- R8: A missing acknowledge on any address byte or written data byte is followed at once by a stop command, and status bit 0 reads 1.
- R9: An enable edge with both write and read set, or with neither set, issues no bus command. It sets the cause bit and status bit 0.
- R10: Completion sets cause bit 0. Status bit 0 reads 0 on success. Writing 0 to the cause register clears the cause bit.
- R11: `irq` is high exactly when cause bit 0 and mask bit 0 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| cmd_valid | output | 1 | Command to the byte engine is pending |
| cmd_op | output | 2 | Command code: 0 start, 1 write, 2 read, 3 stop |
| cmd_data | output | 8 | Byte to send for write commands |
| cmd_nack | output | 1 | Answer NACK after this read byte |
| cmd_done | input | 1 | One-cycle pulse: the pending command finished |
| cmd_ack_in | input | 1 | Slave acknowledged the byte (valid with `cmd_done`) |
| cmd_rdata | input | 8 | Received byte (valid with `cmd_done` on a read) |

## Verification
The sequencer is driven with several transfer shapes:
- 7-bit writes and reads, which check how the address byte is formed.
- 10-bit writes and reads, which check the two-byte address.
- A 5-byte write and an 8-byte read, which cross into the high data word and so tell a wrong byte lane from a correct one.
- A NACK on the address and a NACK on a middle data byte, which show that data stops at the right point.
- Both-direction and no-direction control words, which show the bus is left untouched.

The bench's engine model records every command in the cycle it is issued and compares it against a queue built from the requirements. This catches wrong order, wrong data, wrong acknowledge policy and extra commands, including any command after an enable write that is not a rising edge.

// File: rtl/tw_offload_pkg.sv
// Shared definitions for the two-wire offload sequencer.
// Assumes an 8-byte maximum transfer and a 3-bit length field.
package tw_offload_pkg;
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_START, SQ_ADR1, SQ_ADR2, SQ_XFER, SQ_STOP, SQ_DONE
    } seq_state_e;

    // control word bit positions
    localparam int CTL_WR      = 0;
    localparam int CTL_RD      = 1;
    localparam int CTL_ADR_LSB = 2;
    localparam int CTL_TEN     = 12;
    localparam int CTL_TXN_LSB = 13;
    localparam int CTL_RXN_LSB = 16;
    localparam int CTL_EN      = 19;
    localparam int LEN_W       = 3;

    // register word indices
    localparam int RA_CTRL   = 0;
    localparam int RA_TXLO   = 1;
    localparam int RA_TXHI   = 2;
    localparam int RA_RXLO   = 3;
    localparam int RA_RXHI   = 4;
    localparam int RA_STATUS = 5;
    localparam int RA_CAUSE  = 6;
    localparam int RA_MASK   = 7;
    localparam int RA_TIMING = 8;
endpackage

// File: rtl/tw_offload_regs.sv
// Register file of the offload sequencer: control, transmit/receive words,
// status, cause, mask and timing. Receive bytes are written one lane at a
// time by the sequencer. Assumes a sequencer completion pulse of one cycle.
module tw_offload_regs
    import tw_offload_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_AW = 4,
    localparam int NBYTES = 2 * DATA_W / 8,
    localparam int CNT_W  = $clog2(NBYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic [CTL_EN:0]      ctrl_word,
    output logic [8*NBYTES-1:0]  tx_bytes,
    input  logic                 fin,
    input  logic                 fin_err,
    input  logic                 rx_we,
    input  logic [CNT_W-1:0]     rx_idx,
    input  logic [7:0]           rx_byte,
    output logic                 irq
);
    logic [DATA_W-1:0] ctrl_q, txlo_q, txhi_q, mask_q, timing_q;
    logic              status_err, cause_q;
    logic [7:0]        rx_mem [NBYTES];
    logic [8*NBYTES-1:0] rx_flat;

    function automatic logic hit(input logic [REG_AW-1:0] a, input int idx);
        return a == REG_AW'(idx);
    endfunction

    // software-writable configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            txlo_q   <= '0;
            txhi_q   <= '0;
            mask_q   <= '0;
            timing_q <= '0;
        end else if (reg_wr) begin
            if (hit(reg_addr, RA_CTRL))   ctrl_q   <= reg_wdata;
            if (hit(reg_addr, RA_TXLO))   txlo_q   <= reg_wdata;
            if (hit(reg_addr, RA_TXHI))   txhi_q   <= reg_wdata;
            if (hit(reg_addr, RA_MASK))   mask_q   <= reg_wdata;
            if (hit(reg_addr, RA_TIMING)) timing_q <= reg_wdata;
        end
    end

    // completion status and cause; completion wins over a clearing write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_err <= 1'b0;
            cause_q    <= 1'b0;
        end else if (fin) begin
            status_err <= fin_err;
            cause_q    <= 1'b1;
        end else if (reg_wr && hit(reg_addr, RA_CAUSE)) begin
            cause_q    <= cause_q & reg_wdata[0];
        end
    end

    // one storage lane per received byte
    for (genvar g = 0; g < NBYTES; g++) begin : g_rx
        always_ff @(posedge clk) begin
            if (!rst_n)                                rx_mem[g] <= '0;
            else if (rx_we && rx_idx == CNT_W'(g))     rx_mem[g] <= rx_byte;
        end
        assign rx_flat[8*g +: 8] = rx_mem[g];
    end

    assign ctrl_word = ctrl_q[CTL_EN:0];
    assign tx_bytes  = {txhi_q, txlo_q};
    assign irq       = cause_q & mask_q[0];

    // read multiplexer
    always_comb begin
        reg_rdata = '0;
        if (hit(reg_addr, RA_CTRL))   reg_rdata = ctrl_q;
        if (hit(reg_addr, RA_TXLO))   reg_rdata = txlo_q;
        if (hit(reg_addr, RA_TXHI))   reg_rdata = txhi_q;
        if (hit(reg_addr, RA_RXLO))   reg_rdata = rx_flat[DATA_W-1:0];
        if (hit(reg_addr, RA_RXHI))   reg_rdata = rx_flat[2*DATA_W-1:DATA_W];
        if (hit(reg_addr, RA_STATUS)) reg_rdata = DATA_W'(status_err);
        if (hit(reg_addr, RA_CAUSE))  reg_rdata = DATA_W'(cause_q);
        if (hit(reg_addr, RA_MASK))   reg_rdata = mask_q;
        if (hit(reg_addr, RA_TIMING)) reg_rdata = timing_q;
    end

    // R10: a completion pulse leaves the cause set and the status matching
    assert_fin_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> cause_q && (status_err == $past(fin_err)));

    // R10: a zero write to cause without completion clears it
    assert_cause_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit(reg_addr, RA_CAUSE) && !reg_wdata[0] && !fin) |=> !cause_q);
endmodule

// File: rtl/tw_offload_seq.sv
// Transfer sequencer: on an enable edge it walks start, address, data and
// stop commands over the byte-engine handshake. Assumes the engine pulses
// cmd_done for one cycle per command and that transmit words stay stable
// while a transfer runs.
module tw_offload_seq
    import tw_offload_pkg::*;
#(
    parameter int NBYTES = 8,
    localparam int CNT_W = $clog2(NBYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CTL_EN:0]      ctrl_word,
    input  logic [8*NBYTES-1:0]  tx_bytes,
    output logic                 cmd_valid,
    output bus_op_e              cmd_op,
    output logic [7:0]           cmd_data,
    output logic                 cmd_nack,
    input  logic                 cmd_done,
    input  logic                 cmd_ack_in,
    input  logic [7:0]           cmd_rdata,
    output logic                 fin,
    output logic                 fin_err,
    output logic                 rx_we,
    output logic [CNT_W-1:0]     rx_idx,
    output logic [7:0]           rx_byte
);
    seq_state_e       state;
    logic             en_q, is_rd, ten, err;
    logic [9:0]       adr;
    logic [CNT_W-1:0] cnt, last;
    logic             launch, good;

    assign launch = ctrl_word[CTL_EN] && !en_q && (state == SQ_IDLE);
    assign good   = ctrl_word[CTL_WR] ^ ctrl_word[CTL_RD];

    // state machine and per-transfer context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            en_q  <= 1'b0;
            is_rd <= 1'b0;
            ten   <= 1'b0;
            err   <= 1'b0;
            adr   <= '0;
            cnt   <= '0;
            last  <= '0;
        end else begin
            en_q <= ctrl_word[CTL_EN];
            case (state)
                SQ_IDLE: if (launch) begin
                    is_rd <= ctrl_word[CTL_RD];
                    ten   <= ctrl_word[CTL_TEN];
                    adr   <= ctrl_word[CTL_ADR_LSB +: 10];
                    last  <= ctrl_word[CTL_RD] ? CNT_W'(ctrl_word[CTL_RXN_LSB +: LEN_W])
                                               : CNT_W'(ctrl_word[CTL_TXN_LSB +: LEN_W]);
                    cnt   <= '0;
                    err   <= !good;
                    state <= good ? SQ_START : SQ_DONE;
                end
                SQ_START: if (cmd_done) state <= SQ_ADR1;
                SQ_ADR1: if (cmd_done) begin
                    if (!cmd_ack_in) begin
                        err   <= 1'b1;
                        state <= SQ_STOP;
                    end else begin
                        state <= ten ? SQ_ADR2 : SQ_XFER;
                    end
                end
                SQ_ADR2: if (cmd_done) begin
                    if (!cmd_ack_in) begin
                        err   <= 1'b1;
                        state <= SQ_STOP;
                    end else begin
                        state <= SQ_XFER;
                    end
                end
                SQ_XFER: if (cmd_done) begin
                    if (!is_rd && !cmd_ack_in) begin
                        err   <= 1'b1;
                        state <= SQ_STOP;
                    end else if (cnt == last) begin
                        state <= SQ_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_STOP: if (cmd_done) state <= SQ_DONE;
                SQ_DONE: state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // command presented to the byte engine for the current state
    always_comb begin
        cmd_valid = 1'b0;
        cmd_op    = OP_START;
        cmd_data  = 8'h00;
        cmd_nack  = 1'b0;
        case (state)
            SQ_START: cmd_valid = 1'b1;
            SQ_ADR1: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_WRITE;
                cmd_data  = ten ? {5'b11110, adr[9:8], is_rd} : {adr[6:0], is_rd};
            end
            SQ_ADR2: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_WRITE;
                cmd_data  = adr[7:0];
            end
            SQ_XFER: begin
                cmd_valid = 1'b1;
                if (is_rd) begin
                    cmd_op   = OP_READ;
                    cmd_nack = (cnt == last);
                end else begin
                    cmd_op   = OP_WRITE;
                    cmd_data = tx_bytes[{cnt, 3'b000} +: 8];
                end
            end
            SQ_STOP: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_STOP;
            end
            default: ;
        endcase
    end

    assign fin     = (state == SQ_DONE);
    assign fin_err = err;
    assign rx_we   = (state == SQ_XFER) && is_rd && cmd_done;
    assign rx_idx  = cnt;
    assign rx_byte = cmd_rdata;

    // R3: a pending command holds steady until the engine finishes it
    assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=> cmd_valid && $stable(cmd_op) && $stable(cmd_data));

    // R3: a legal launch opens with a start command
    assert_first_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && good) |=> cmd_valid && cmd_op == OP_START);

    // R9: an illegal launch completes with error and no bus command
    assert_bad_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !good) |=> !cmd_valid && fin && fin_err);

    // R8: a refused written byte is followed directly by stop
    assert_nack_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WRITE && cmd_done && !cmd_ack_in)
        |=> cmd_valid && cmd_op == OP_STOP);

    // R10: a finished stop leads to the completion pulse
    assert_stop_fin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_STOP && cmd_done) |=> fin);
endmodule

// File: rtl/tw_offload_top.sv
// Top of the two-wire transaction offload sequencer: register file plus
// sequencer, presenting a register port, an interrupt and a byte-engine port.
module tw_offload_top
    import tw_offload_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [7:0]        cmd_data,
    output logic              cmd_nack,
    input  logic              cmd_done,
    input  logic              cmd_ack_in,
    input  logic [7:0]        cmd_rdata
);
    localparam int NBYTES = 2 * DATA_W / 8;
    localparam int CNT_W  = $clog2(NBYTES);

    logic [CTL_EN:0]     ctrl_word;
    logic [8*NBYTES-1:0] tx_bytes;
    logic                fin, fin_err, rx_we;
    logic [CNT_W-1:0]    rx_idx;
    logic [7:0]          rx_byte;
    bus_op_e             op_int;

    tw_offload_regs #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ctrl_word(ctrl_word), .tx_bytes(tx_bytes),
        .fin(fin), .fin_err(fin_err), .rx_we(rx_we), .rx_idx(rx_idx),
        .rx_byte(rx_byte), .irq(irq)
    );

    tw_offload_seq #(.NBYTES(NBYTES)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .ctrl_word(ctrl_word), .tx_bytes(tx_bytes),
        .cmd_valid(cmd_valid), .cmd_op(op_int), .cmd_data(cmd_data),
        .cmd_nack(cmd_nack), .cmd_done(cmd_done), .cmd_ack_in(cmd_ack_in),
        .cmd_rdata(cmd_rdata), .fin(fin), .fin_err(fin_err),
        .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte)
    );

    assign cmd_op = op_int;
endmodule

// File: tb/tb_tw_offload_top.sv
`timescale 1ns/1ps
module tb_tw_offload_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, cmd_valid, cmd_nack;
    logic [1:0]  cmd_op;
    logic [7:0]  cmd_data;
    logic        cmd_done = 1'b0;
    logic        cmd_ack_in = 1'b0;
    logic [7:0]  cmd_rdata = '0;

    always #2.5 clk = ~clk;

    tw_offload_top dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .cmd_nack(cmd_nack), .cmd_done(cmd_done), .cmd_ack_in(cmd_ack_in),
        .cmd_rdata(cmd_rdata)
    );

    int    n_chk = 0, n_fail = 0;
    int    exp_q[$];
    int    eng_idx = 0, eng_nack_at = -1, eng_rd = 0, eng_cnt = 0, code = 0, front = 0;
    bit    eng_busy = 0;
    string cur_tag = "R3";

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // behavioural byte engine: logs each command against the expected queue
    always @(negedge clk) begin
        if (!rst_n) begin
            cmd_done = 1'b0;
            eng_busy = 1'b0;
        end else if (eng_busy) begin
            if (eng_cnt == 0) begin
                cmd_done = 1'b1;
                eng_busy = 1'b0;
            end else eng_cnt--;
        end else begin
            cmd_done = 1'b0;
            if (cmd_valid) begin
                code = int'(cmd_op) * 512 + int'(cmd_nack) * 256 + int'(cmd_data);
                if (exp_q.size() == 0) check("R3", "unexpected bus command", code, -1);
                else begin
                    front = exp_q.pop_front();
                    check(cur_tag, "bus command {op,nack,data}", code, front);
                end
                cmd_ack_in = (eng_idx != eng_nack_at);
                if (cmd_op == 2'd2) begin
                    cmd_rdata = 8'hA0 + 8'(eng_rd);
                    eng_rd++;
                end
                eng_idx++;
                eng_busy = 1'b1;
                eng_cnt  = 2;
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 4'(a);
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] ctl(input bit w, input bit r, input int addr,
                                        input bit ten, input int txn, input int rxn);
        return 32'h0008_0000 | 32'(w) | (32'(r) << 1) | (32'(addr & 10'h3FF) << 2)
             | (32'(ten) << 12) | (32'((txn - 1) & 7) << 13) | (32'((rxn - 1) & 7) << 16);
    endfunction

    // run one transfer and check commands, status and received data
    task automatic run(input string tag, input bit is_rd, input bit ten, input int addr,
                       input int n, input int nack_at, input logic [63:0] txd,
                       input bit exp_err, input bit hold);
        int list[$];
        logic [31:0] v, lo, hi;
        bit seen;
        cur_tag = tag;
        list.push_back(0);
        if (ten) begin
            list.push_back(512 + (8'hF0 | ((addr >> 7) & 6) | int'(is_rd)));
            list.push_back(512 + (addr & 8'hFF));
        end else begin
            list.push_back(512 + (((addr & 7'h7F) << 1) | int'(is_rd)));
        end
        for (int k = 0; k < n; k++) begin
            if (is_rd) list.push_back(1024 + ((k == n - 1) ? 256 : 0));
            else       list.push_back(512 + int'(txd[8*k +: 8]));
        end
        if (nack_at >= 0) while (list.size() > nack_at + 1) void'(list.pop_back());
        list.push_back(3 * 512);
        exp_q = list;
        eng_idx = 0; eng_rd = 0; eng_nack_at = nack_at;
        if (!is_rd) begin
            wr(1, txd[31:0]);
            wr(2, txd[63:32]);
        end
        wr(0, ctl(!is_rd, is_rd, addr, ten, is_rd ? 1 : n, is_rd ? n : 1));
        seen = 0;
        for (int i = 0; i < 300 && !seen; i++) begin
            rd(6, v);
            seen = v[0];
        end
        check("R10", {tag, " completion cause"}, longint'(seen), 1);
        check("R3", {tag, " all commands issued"}, exp_q.size(), 0);
        rd(5, v);
        check(exp_err ? "R8" : "R10", {tag, " status error bit"}, v, 32'(exp_err));
        if (is_rd && !exp_err) begin
            rd(3, lo); rd(4, hi);
            for (int k = 0; k < n; k++)
                check("R7", {tag, " received byte"}, k < 4 ? lo[8*k +: 8] : hi[8*(k-4) +: 8], 8'hA0 + k);
        end
        if (!hold) wr(0, 0);
        wr(6, 0);
        rd(6, v);
        check("R10", {tag, " cause cleared"}, v, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a <= 8; a++) begin
            rd(a, v);
            check("R1", "register after reset", v, 0);
        end
        check("R1", "irq after reset", irq, 0);
        check("R1", "cmd_valid after reset", cmd_valid, 0);

        // R2: read-back and read-only registers
        wr(0, 32'h0007_FFFC); rd(0, v); check("R2", "control readback", v, 32'h0007_FFFC);
        wr(1, 32'h1234_5678); rd(1, v); check("R2", "tx low readback", v, 32'h1234_5678);
        wr(2, 32'h9ABC_DEF0); rd(2, v); check("R2", "tx high readback", v, 32'h9ABC_DEF0);
        wr(8, 32'h0000_0F3C); rd(8, v); check("R2", "timing readback", v, 32'h0000_0F3C);
        wr(7, 32'h0000_0000); rd(7, v); check("R2", "mask readback", v, 0);
        wr(5, 32'hFFFF_FFFF); rd(5, v); check("R2", "status ignores write", v, 0);
        wr(3, 32'hFFFF_FFFF); rd(3, v); check("R2", "rx low ignores write", v, 0);
        wr(0, 0);
        check("R3", "no command without enable edge", eng_idx, 0);

        // R4/R6: 7-bit write, three bytes
        run("R4", 0, 0, 7'h52, 3, -1, 64'h0000_0000_00C3_B2A1, 0, 0);
        // R7: 7-bit read, eight bytes with NACK on the last
        run("R7", 1, 0, 7'h1D, 8, -1, 64'h0, 0, 0);
        // R5/R6: 10-bit write, five bytes reaching the high word
        run("R5", 0, 1, 10'h2A5, 5, -1, 64'h0000_00E5_D4C3_B2A1, 0, 0);
        // R5: 10-bit read, two bytes
        run("R5", 1, 1, 10'h13C, 2, -1, 64'h0, 0, 0);
        // R6: 7-bit write of all eight lanes
        run("R6", 0, 0, 7'h7F, 8, -1, 64'h8877_6655_4433_2211, 0, 0);
        // R8: address refused
        run("R8", 0, 0, 7'h33, 4, 1, 64'h0000_0000_4433_2211, 1, 0);
        // R8: second data byte refused
        run("R8", 0, 0, 7'h33, 4, 3, 64'h0000_0000_4433_2211, 1, 0);

        // R3: rewriting control with enable held starts nothing
        run("R3", 0, 0, 7'h10, 1, -1, 64'h5A, 0, 1);
        eng_idx = 0;
        wr(0, ctl(1, 0, 7'h10, 0, 1, 1));
        repeat (30) @(negedge clk);
        check("R3", "no relaunch with enable held", eng_idx, 0);
        rd(6, v); check("R3", "cause stays clear with enable held", v, 0);
        wr(0, 0);

        // R9: both directions set
        eng_idx = 0; exp_q.delete();
        wr(0, 32'h0008_0003);
        repeat (5) @(negedge clk);
        check("R9", "no command when both set", eng_idx, 0);
        rd(6, v); check("R9", "cause when both set", v, 1);
        rd(5, v); check("R9", "status when both set", v, 1);
        // R11: interrupt gating by mask bit 0
        check("R11", "irq with mask clear", irq, 0);
        wr(7, 1); #1 check("R11", "irq with mask set", irq, 1);
        wr(6, 0); #1 check("R11", "irq after cause cleared", irq, 0);
        wr(0, 0);
        // R9: neither direction set
        wr(0, 32'h0008_0000);
        repeat (5) @(negedge clk);
        check("R9", "no command when neither set", eng_idx, 0);
        rd(5, v); check("R9", "status when neither set", v, 1);
        #1 check("R11", "irq on completion with mask set", irq, 1);
        wr(0, 0); wr(6, 0);

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule